// File: doc/BRIEF.md
# Instruction-Decoding Integer Execute Unit

This block is a purely combinational execute stage for a small 32-bit load/store-style integer core. It takes a raw 32-bit instruction word and the two source register values already read from the register file. In the same cycle it produces the result, the index of the register to write, a write strobe and a flag for instructions it does not recognise. The decode is built into the unit, so no separate decoder sits in front of it.

Two instruction layouts are recognised. In both, the opcode is in bits [31:26], the first source index in [25:21] and the second source index in [20:16]. Register-format words have opcode 0 and add a destination index in [15:11], a shift amount in [10:6] and a function selector in [5:0]. Immediate-format words carry a 16-bit constant in [15:0] and write the register named in [20:16].

Register 0 is hard-wired to zero, so a write aimed at it is dropped. There is no clock inside the unit. The surrounding pipeline samples the outputs whenever it captures its own registers.

Top module: `exu_core`

## Requirements
- R1: With opcode 0, function 32 returns rs+rt and function 34 returns rs-rt, both modulo 2^32 with no overflow trap. The destination is instruction bits [15:11].
- R2: With opcode 0, function 36 returns rs AND rt, function 37 returns rs OR rt, and function 39 returns NOT(rs OR rt).
- R3: With opcode 0, function 42 returns 1 when rs is less than rt as signed two's complement, and 0 otherwise.
- R4: With opcode 0, function 0 shifts rt left and function 2 shifts rt right, both filling with zeros. The shift distance is instruction bits [10:6] (0 to 31), and the rs value does not affect the result.
- R5: Opcode 8 returns rs plus the sign-extended immediate. Opcode 10 returns 1 when rs is signed-less-than the sign-extended immediate, and 0 otherwise. The destination for both is instruction bits [20:16].
- R6: Opcode 12 returns rs AND the zero-extended immediate, and opcode 13 returns rs OR the zero-extended immediate. The destination is instruction bits [20:16].
- R7: Opcode 15 places the immediate in result bits [31:16] with zeros in [15:0]. The rs value has no effect.
- R8: A recognised instruction whose destination index is 0 keeps wr_en_o low. Otherwise, a recognised instruction drives wr_en_o high.
- R9: Any other opcode, or opcode 0 with any other function value, raises illegal_o and drives wr_en_o, result_o and dest_o to 0.
- R10: A recognised instruction keeps illegal_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to execute |
| rs_val_i | input | DATA_W | Value of the first source register |
| rt_val_i | input | DATA_W | Value of the second source register |
| result_o | output | DATA_W | Computed result (0 when illegal) |
| dest_o | output | 5 | Destination register index (0 when illegal) |
| wr_en_o | output | 1 | Register-file write strobe |
| illegal_o | output | 1 | Instruction not recognised |

## Verification
The bench uses the default DATA_W of 32, which is the only width the instruction layout defines. At that width the whole decode space is small enough to cover completely. Every one of the 64 opcodes and every one of the 64 function values is applied, every shift distance from 0 to 31 is swept in both directions, and every destination index from 0 to 31 is tried for both formats. Operand values are drawn from a computed set that includes the sign boundaries 0x7FFFFFFF and 0x80000000, so the signed compares, sign extension and wrap-around are all reached.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int RIDX_W  = 5;
  localparam int IMM_W   = 16;
  localparam int SHF_W   = 5;

  localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'd8;
  localparam logic [OPC_W-1:0] OPC_SLTI = 6'd10;
  localparam logic [OPC_W-1:0] OPC_ANDI = 6'd12;
  localparam logic [OPC_W-1:0] OPC_ORI  = 6'd13;
  localparam logic [OPC_W-1:0] OPC_LUI  = 6'd15;

  localparam logic [FN_W-1:0] FN_SLL = 6'd0;
  localparam logic [FN_W-1:0] FN_SRL = 6'd2;
  localparam logic [FN_W-1:0] FN_ADD = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB = 6'd34;
  localparam logic [FN_W-1:0] FN_AND = 6'd36;
  localparam logic [FN_W-1:0] FN_OR  = 6'd37;
  localparam logic [FN_W-1:0] FN_NOR = 6'd39;
  localparam logic [FN_W-1:0] FN_SLT = 6'd42;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_NOR, K_SLT, K_SLL, K_SRL, K_PASSB, K_BAD
  } alu_kind_e;

  typedef enum logic [1:0] {
    B_REG, B_SEXT, B_ZEXT, B_HIGH
  } bsel_e;

  typedef struct packed {
    alu_kind_e         kind;
    bsel_e             bsel;
    logic [RIDX_W-1:0] dest;
    logic              legal;
  } dec_t;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [OPC_W-1:0]  opc_i,
  input  logic [FN_W-1:0]   fn_i,
  input  logic [RIDX_W-1:0] rt_idx_i,
  input  logic [RIDX_W-1:0] rd_idx_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o.kind  = K_BAD;
    dec_o.bsel  = B_REG;
    dec_o.dest  = rt_idx_i;
    dec_o.legal = 1'b1;
    case (opc_i)
      OPC_REG: begin
        dec_o.dest = rd_idx_i;
        case (fn_i)
          FN_ADD:  dec_o.kind = K_ADD;
          FN_SUB:  dec_o.kind = K_SUB;
          FN_AND:  dec_o.kind = K_AND;
          FN_OR:   dec_o.kind = K_OR;
          FN_NOR:  dec_o.kind = K_NOR;
          FN_SLT:  dec_o.kind = K_SLT;
          FN_SLL:  dec_o.kind = K_SLL;
          FN_SRL:  dec_o.kind = K_SRL;
          default: dec_o.legal = 1'b0;
        endcase
      end
      OPC_ADDI: begin dec_o.kind = K_ADD;   dec_o.bsel = B_SEXT; end
      OPC_SLTI: begin dec_o.kind = K_SLT;   dec_o.bsel = B_SEXT; end
      OPC_ANDI: begin dec_o.kind = K_AND;   dec_o.bsel = B_ZEXT; end
      OPC_ORI:  begin dec_o.kind = K_OR;    dec_o.bsel = B_ZEXT; end
      OPC_LUI:  begin dec_o.kind = K_PASSB; dec_o.bsel = B_HIGH; end
      default:  dec_o.legal = 1'b0;
    endcase
  end

  always_comb begin
    if (!dec_o.legal) p_bad_kind_r9: assert (dec_o.kind == K_BAD);
    if (dec_o.legal)  p_good_kind_r10: assert (dec_o.kind != K_BAD);
  end
endmodule

// File: rtl/exu_operand.sv
module exu_operand
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  bsel_e              bsel_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [DATA_W-1:0]  rt_val_i,
  output logic [DATA_W-1:0]  b_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  always_comb begin
    case (bsel_i)
      B_SEXT:  b_o = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
      B_ZEXT:  b_o = {{EXT_W{1'b0}}, imm_i};
      B_HIGH:  b_o = {imm_i, {EXT_W{1'b0}}};
      default: b_o = rt_val_i;
    endcase
  end

  always_comb begin
    if (bsel_i == B_HIGH) p_high_low_zero_r7: assert (b_o[EXT_W-1:0] == '0);
  end
endmodule

// File: rtl/exu_shifter.sv
module exu_shifter #(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [SH_W-1:0]   amt_i,
  input  logic              left_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] stage [0:SH_W];

  assign stage[0] = val_i;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    always_comb begin
      if (!amt_i[k])   stage[k+1] = stage[k];
      else if (left_i) stage[k+1] = stage[k] << STEP;
      else             stage[k+1] = stage[k] >> STEP;
    end
  end

  assign res_o = stage[SH_W];

  always_comb begin
    if (amt_i == '0) p_zero_shift_r4: assert (res_o == val_i);
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  alu_kind_e          kind_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [SH_W-1:0]    amt_i,
  output logic [DATA_W-1:0]  res_o
);
  logic [DATA_W-1:0] shifted;
  logic              lt;

  exu_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
    .val_i (b_i),
    .amt_i (amt_i),
    .left_i(kind_i == K_SLL),
    .res_o (shifted)
  );

  assign lt = $signed(a_i) < $signed(b_i);

  always_comb begin
    case (kind_i)
      K_ADD:   res_o = a_i + b_i;
      K_SUB:   res_o = a_i - b_i;
      K_AND:   res_o = a_i & b_i;
      K_OR:    res_o = a_i | b_i;
      K_NOR:   res_o = ~(a_i | b_i);
      K_SLT:   res_o = {{(DATA_W-1){1'b0}}, lt};
      K_SLL,
      K_SRL:   res_o = shifted;
      K_PASSB: res_o = b_i;
      default: res_o = '0;
    endcase
  end

  always_comb begin
    if (kind_i == K_SUB) p_sub_inverse_r1: assert (res_o + b_i == a_i);
    if (kind_i == K_NOR) p_nor_disjoint_r2: assert ((res_o & (a_i | b_i)) == '0);
    if (kind_i == K_SLT) p_slt_bool_r3: assert (res_o[DATA_W-1:1] == '0);
  end
endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  rs_val_i,
  input  logic [DATA_W-1:0]  rt_val_i,
  output logic [DATA_W-1:0]  result_o,
  output logic [RIDX_W-1:0]  dest_o,
  output logic               wr_en_o,
  output logic               illegal_o
);
  localparam int SH_W = SHF_W;

  logic [OPC_W-1:0]  opc;
  logic [FN_W-1:0]   fn;
  logic [RIDX_W-1:0] rt_idx;
  logic [RIDX_W-1:0] rd_idx;
  logic [SH_W-1:0]   amt;
  logic [IMM_W-1:0]  imm;
  dec_t              dec;
  logic [DATA_W-1:0] b_val;
  logic [DATA_W-1:0] alu_res;

  assign opc    = instr_i[31:26];
  assign rt_idx = instr_i[20:16];
  assign rd_idx = instr_i[15:11];
  assign amt    = instr_i[10:6];
  assign fn     = instr_i[5:0];
  assign imm    = instr_i[15:0];

  exu_decode u_dec (
    .opc_i   (opc),
    .fn_i    (fn),
    .rt_idx_i(rt_idx),
    .rd_idx_i(rd_idx),
    .dec_o   (dec)
  );

  exu_operand #(.DATA_W(DATA_W)) u_opnd (
    .bsel_i  (dec.bsel),
    .imm_i   (imm),
    .rt_val_i(rt_val_i),
    .b_o     (b_val)
  );

  exu_alu #(.DATA_W(DATA_W), .SH_W(SH_W)) u_alu (
    .kind_i(dec.kind),
    .a_i   (rs_val_i),
    .b_i   (b_val),
    .amt_i (amt),
    .res_o (alu_res)
  );

  always_comb begin
    result_o  = dec.legal ? alu_res : '0;
    dest_o    = dec.legal ? dec.dest : '0;
    wr_en_o   = dec.legal && (dec.dest != '0);
    illegal_o = !dec.legal;
  end

  always_comb begin
    if (wr_en_o) p_no_zero_write_r8: assert (dest_o != '0);
    if (illegal_o) p_illegal_quiet_r9: assert (!wr_en_o && result_o == '0);
    if (!illegal_o && opc == OPC_REG) p_rdest_r1: assert (dest_o == instr_i[15:11]);
    if (!illegal_o && opc != OPC_REG) p_idest_r5: assert (dest_o == instr_i[20:16]);
    if (!illegal_o && opc == OPC_LUI) p_lui_upper_r7: assert (result_o[31:16] == instr_i[15:0]);
  end
endmodule

// File: tb/sim_exu_core.sv
module sim_exu_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr;
  logic [31:0] rs_v;
  logic [31:0] rt_v;
  logic [31:0] res;
  logic [4:0]  dest;
  logic        we;
  logic        ill;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  exu_core u0 (
    .instr_i  (instr),
    .rs_val_i (rs_v),
    .rt_val_i (rt_v),
    .result_o (res),
    .dest_o   (dest),
    .wr_en_o  (we),
    .illegal_o(ill)
  );

  function automatic logic [31:0] pat(input int i);
    case (i % 16)
      0: pat = 32'h0000_0000;
      1: pat = 32'h0000_0001;
      2: pat = 32'hFFFF_FFFF;
      3: pat = 32'h8000_0000;
      4: pat = 32'h7FFF_FFFF;
      5: pat = 32'h0000_8000;
      6: pat = 32'h0000_7FFF;
      7: pat = 32'hFFFF_8000;
      default: pat = 32'h9E37_79B9 * (i + 3) ^ (32'h1234_5678 >> (i % 7));
    endcase
  endfunction

  function automatic string rtag(input logic [31:0] w);
    if (w[31:26] == 6'd0) begin
      case (w[5:0])
        6'd32, 6'd34:        rtag = "R1";
        6'd36, 6'd37, 6'd39: rtag = "R2";
        6'd42:               rtag = "R3";
        6'd0, 6'd2:          rtag = "R4";
        default:             rtag = "R9";
      endcase
    end else begin
      case (w[31:26])
        6'd8, 6'd10:  rtag = "R5";
        6'd12, 6'd13: rtag = "R6";
        6'd15:        rtag = "R7";
        default:      rtag = "R9";
      endcase
    end
  endfunction

  task automatic model(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] e_res, output logic [4:0] e_dst,
                       output logic e_we, output logic e_ill);
    logic [31:0] sx;
    logic [31:0] zx;
    sx = {{16{w[15]}}, w[15:0]};
    zx = {16'h0, w[15:0]};
    e_ill = 1'b0;
    e_res = 32'h0;
    e_dst = (w[31:26] == 6'd0) ? w[15:11] : w[20:16];
    case (w[31:26])
      6'd0: case (w[5:0])
        6'd32: e_res = a + b;
        6'd34: e_res = a - b;
        6'd36: e_res = a & b;
        6'd37: e_res = a | b;
        6'd39: e_res = ~(a | b);
        6'd42: e_res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        6'd0:  e_res = b << w[10:6];
        6'd2:  e_res = b >> w[10:6];
        default: e_ill = 1'b1;
      endcase
      6'd8:  e_res = a + sx;
      6'd10: e_res = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
      6'd12: e_res = a & zx;
      6'd13: e_res = a | zx;
      6'd15: e_res = {w[15:0], 16'h0};
      default: e_ill = 1'b1;
    endcase
    if (e_ill) begin
      e_res = 32'h0;
      e_dst = 5'd0;
    end
    e_we = !e_ill && (e_dst != 5'd0);
  endtask

  task automatic apply(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                       input string tag);
    logic [31:0] e_res;
    logic [4:0]  e_dst;
    logic        e_we;
    logic        e_ill;
    @(posedge clk);
    #1;
    instr = w;
    rs_v  = a;
    rt_v  = b;
    model(w, a, b, e_res, e_dst, e_we, e_ill);
    @(negedge clk);
    checks++;
    if (res !== e_res || dest !== e_dst || we !== e_we || ill !== e_ill) begin
      failures++;
      $display("FAIL %s instr=%h act res=%h dst=%0d we=%b ill=%b exp res=%h dst=%0d we=%b ill=%b",
               tag, w, res, dest, we, ill, e_res, e_dst, e_we, e_ill);
    end
  endtask

  function automatic logic [31:0] rword(input logic [5:0] fn, input int i, input logic [4:0] sh);
    rword = {6'd0, 5'(i * 3), 5'(i + 7), 5'(i), sh, fn};
  endfunction

  initial begin
    logic [5:0] fns [8];
    logic [5:0] ops [5];
    fns = '{6'd32, 6'd34, 6'd36, 6'd37, 6'd39, 6'd42, 6'd0, 6'd2};
    ops = '{6'd8, 6'd10, 6'd12, 6'd13, 6'd15};
    instr = 32'h0;
    rs_v  = 32'h0;
    rt_v  = 32'h0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;

    // reset/idle state: all-zero word is a shift into register 0 (R8)
    apply(32'h0, 32'h0, 32'h0, "R8");

    // register-format operations over operand pairs (R1 R2 R3 R4)
    for (int f = 0; f < 8; f++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          apply(rword(fns[f], i + j + 1, 5'(j)), pat(i), pat(j), rtag(rword(fns[f], 1, 0)));

    // full shift distance sweep in both directions; rs must not matter (R4)
    for (int s = 0; s < 32; s++)
      for (int i = 0; i < 8; i++) begin
        apply(rword(6'd0, 9, 5'(s)), pat(i + 2), pat(i + 8), "R4");
        apply(rword(6'd2, 9, 5'(s)), ~pat(i), pat(i + 8), "R4");
      end

    // immediate-format operations (R5 R6 R7)
    for (int o = 0; o < 5; o++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          apply({ops[o], 5'(i), 5'(j + 1), pat(j)[15:0]}, pat(i), pat(j + 5),
                rtag({ops[o], 26'h0}));

    // every opcode and every function value (R9 R10)
    for (int o = 0; o < 64; o++)
      apply({6'(o), 5'd3, 5'd4, 16'h8421}, 32'h0F0F_1234, 32'h8000_0003, rtag({6'(o), 26'h21}));
    for (int f = 0; f < 64; f++)
      apply(rword(6'(f), 5, 5'd3), 32'hDEAD_BEEF, 32'h0000_00F1, rtag(rword(6'(f), 1, 0)));

    // every destination index in both formats (R8 R10)
    for (int d = 0; d < 32; d++) begin
      apply({6'd0, 5'd1, 5'd2, 5'(d), 5'd0, 6'd32}, 32'd5, 32'd6, "R8");
      apply({6'd8, 5'd1, 5'(d), 16'hFFFF}, 32'd5, 32'd6, "R8");
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule